// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block runs the calibration steps of a sigma-delta converter. It supports four of them: an internal offset step and an internal gain step, and a system offset step and a system gain step. For the system steps the external zero or full-scale signal is applied at the input pins beforehand. Software starts a step by writing its code into the mode field. If the request is legal, the sequencer routes the modulator input through a select output. It then asks the converter core for one measurement and waits for the core's done handshake. When the handshake arrives, it writes the measured word into the offset or gain coefficient of the setup that the single enabled channel uses. After that it falls back to standby.

While a step runs, the ready status bit and the ready pin are high. At the end the status bit always clears. The pin clears only while chip select is asserted (low); otherwise it stays high until chip select next goes low. A request is refused, with a sticky error bit, in three cases. The first is when the channel-enable mask does not hold exactly one channel. The second is an internal gain step on a channel wired as a current input. The third is any gain step for a setup whose offset has not been calibrated since its reference selection last changed.

Top module: `cal_sequencer`

## Requirements
- R1: A calibration code (1 internal offset, 2 internal gain, 3 system offset, 4 system gain) written while idle with zero or more than one bit set in `ch_en` is refused. On the next clock `cal_err` is 1, `mode_cur` keeps its old value, and `rdy_bit`, `rdy_pin` and `conv_start` stay low.
- R2: An accepted calibration code makes `rdy_bit` and `rdy_pin` 1 and `mode_cur` equal to the code on the next clock. It also clears `cal_err` and pulses `conv_start` for exactly that one cycle.
- R3: While a step runs, `mux_sel` is 1 (both modulator inputs on the negative input) for the internal offset step, 2 (internal full-scale source) for the internal gain step, and 0 (normal pins) for the system steps. When no step runs, `mux_sel` is 0.
- R4: `conv_done` is acted on only once the cycle after `conv_start` has passed. On the clock that samples it, the sequencer pulses `coef_wr_en` for one cycle. In that cycle `coef_wr_gain` is 0 for offset steps and 1 for gain steps, `coef_wr_setup` names the setup of the calibrated channel, and `coef_wr_data` equals `conv_result`. In the same cycle `rdy_bit` is 0 and `mode_cur` is 0 (standby). `conv_done` is ignored while no step waits for it.
- R5: `rdy_pin` falls at the end of a step only if `cs_n` is 0. While `cs_n` is 1 it stays high, and it falls on the first clock after completion that samples `cs_n` low.
- R6: An internal gain request on a channel whose `ch_is_current` bit is 1 is refused in the same way as in R1.
- R7: A gain request (code 2 or 4) is refused unless the channel's setup has a valid offset. A setup's offset becomes valid when an offset step (code 1 or 3) finishes on it.
- R8: A change of a setup's field in `ref_sel` invalidates that setup's offset, so that a later gain request on it is refused.
- R9: Mode writes that arrive while a step is running are ignored: `mode_cur`, `cal_err` and the step in progress are unaffected.
- R10: A non-calibration code (0, 5, 6 or 7) written while idle is stored in `mode_cur` on the next clock and clears `cal_err`, without raising ready or starting a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | Mode code being written |
| ch_en | input | NUM_CH | Channel-enable mask |
| ch_setup | input | NUM_CH*SETUP_W | Setup index for each channel, packed |
| ch_is_current | input | NUM_CH | Marks channels that are current inputs |
| ref_sel | input | NUM_SETUP*REF_W | Reference selection for each setup, packed |
| cs_n | input | 1 | Chip select, active low |
| conv_done | input | 1 | Measurement complete from the converter core |
| conv_result | input | DATA_W | Measured word from the core |
| conv_start | output | 1 | One-cycle measurement request to the core |
| mux_sel | output | 2 | Input routing select (0 pins, 1 short to negative, 2 full-scale source) |
| coef_wr_en | output | 1 | Coefficient write strobe |
| coef_wr_gain | output | 1 | 0 writes the offset coefficient, 1 the gain coefficient |
| coef_wr_setup | output | SETUP_W | Setup whose coefficient is written |
| coef_wr_data | output | DATA_W | Coefficient value |
| mode_cur | output | 3 | Current mode field |
| rdy_bit | output | 1 | Ready status bit, high while calibrating |
| rdy_pin | output | 1 | Ready output pin |
| cal_err | output | 1 | Sticky refusal flag |

## Verification
The assertions assume the core raises `conv_done` only after a `conv_start` it has been given, and that the channel-to-setup map and the current-input marks stay fixed while a step runs. The stimulus changes `ch_setup` and `ch_is_current` only at time zero. It sends `conv_done` several cycles after the start pulse, except for deliberate stray pulses while idle. It moves `ref_sel` only while no step is in flight and never in the cycle of a mode write. Chip select is driven freely, which covers the pin both when it is released during a step and when it is held high afterwards.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam logic [2:0] MODE_STANDBY = 3'd0;
  localparam logic [2:0] MODE_INT_ZS  = 3'd1;
  localparam logic [2:0] MODE_INT_FS  = 3'd2;
  localparam logic [2:0] MODE_SYS_ZS  = 3'd3;
  localparam logic [2:0] MODE_SYS_FS  = 3'd4;

  localparam logic [1:0] MUX_PINS      = 2'd0;
  localparam logic [1:0] MUX_SHORT_NEG = 2'd1;
  localparam logic [1:0] MUX_FS_SRC    = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;

  function automatic logic is_cal_mode(input logic [2:0] m);
    return (m >= MODE_INT_ZS) && (m <= MODE_SYS_FS);
  endfunction

  function automatic logic is_full_scale(input logic [2:0] m);
    return (m == MODE_INT_FS) || (m == MODE_SYS_FS);
  endfunction

  function automatic logic [1:0] mux_for(input logic [2:0] m);
    case (m)
      MODE_INT_ZS: return MUX_SHORT_NEG;
      MODE_INT_FS: return MUX_FS_SRC;
      default:     return MUX_PINS;
    endcase
  endfunction

endpackage

// File: rtl/cal_chan_select.sv
module cal_chan_select #(
  parameter int NUM_CH  = 8,
  parameter int SETUP_W = 2
) (
  input  logic [NUM_CH-1:0]         ch_en,
  input  logic [NUM_CH*SETUP_W-1:0] ch_setup,
  input  logic [NUM_CH-1:0]         ch_is_current,
  output logic                      one_ch,
  output logic [SETUP_W-1:0]        sel_setup,
  output logic                      sel_current
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic [CNT_W-1:0] en_count;
  logic [IDX_W-1:0] en_index;

  always_comb begin
    en_count = '0;
    en_index = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_en[i]) begin
        en_count = en_count + 1'b1;
        en_index = i[IDX_W-1:0];
      end
    end
  end

  assign one_ch      = (en_count == CNT_W'(1));
  assign sel_setup   = ch_setup[en_index*SETUP_W +: SETUP_W];
  assign sel_current = ch_is_current[en_index];

endmodule

// File: rtl/cal_offset_track.sv
module cal_offset_track #(
  parameter int NUM_SETUP = 4,
  parameter int SETUP_W   = 2,
  parameter int REF_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SETUP*REF_W-1:0] ref_sel,
  input  logic                       set_en,
  input  logic [SETUP_W-1:0]         set_setup,
  output logic [NUM_SETUP-1:0]       offset_valid
);

  for (genvar s = 0; s < NUM_SETUP; s++) begin : g_setup
    logic [REF_W-1:0] ref_q;
    logic             ref_chg;
    logic             hit;

    assign ref_chg = (ref_sel[s*REF_W +: REF_W] != ref_q);
    assign hit     = set_en && (set_setup == SETUP_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q           <= '0;
        offset_valid[s] <= 1'b0;
      end else begin
        ref_q <= ref_sel[s*REF_W +: REF_W];
        if (ref_chg)  offset_valid[s] <= 1'b0;
        else if (hit) offset_valid[s] <= 1'b1;
      end
    end

    AST_REF_CLEARS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      ref_chg |=> !offset_valid[s]); // R8
    AST_OFFSET_BECOMES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ref_chg) |=> offset_valid[s]); // R7
  end

endmodule

// File: rtl/cal_ready_out.sv
module cal_ready_out (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic cal_start,
  input  logic cal_finish,
  input  logic busy,
  output logic rdy_pin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rdy_pin <= 1'b0;
    else if (cal_start)                     rdy_pin <= 1'b1;
    else if (!cs_n && (!busy || cal_finish)) rdy_pin <= 1'b0;
  end

  AST_PIN_RISES_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> rdy_pin); // R2
  AST_PIN_HELD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pin && cs_n) |=> rdy_pin); // R5
  AST_PIN_DROPS_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cal_start && (!busy || cal_finish)) |=> !rdy_pin); // R5

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_SETUP = 4,
  parameter int DATA_W    = 24,
  parameter int REF_W     = 2,
  parameter int SETUP_W   = (NUM_SETUP > 1) ? $clog2(NUM_SETUP) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_wr,
  input  logic [2:0]                 mode_wdata,
  input  logic [NUM_CH-1:0]          ch_en,
  input  logic [NUM_CH*SETUP_W-1:0]  ch_setup,
  input  logic [NUM_CH-1:0]          ch_is_current,
  input  logic [NUM_SETUP*REF_W-1:0] ref_sel,
  input  logic                       cs_n,
  input  logic                       conv_done,
  input  logic [DATA_W-1:0]          conv_result,
  output logic                       conv_start,
  output logic [1:0]                 mux_sel,
  output logic                       coef_wr_en,
  output logic                       coef_wr_gain,
  output logic [SETUP_W-1:0]         coef_wr_setup,
  output logic [DATA_W-1:0]          coef_wr_data,
  output logic [2:0]                 mode_cur,
  output logic                       rdy_bit,
  output logic                       rdy_pin,
  output logic                       cal_err
);

  seq_state_t             state_q;
  logic [SETUP_W-1:0]     cal_setup_q;
  logic                   one_ch;
  logic [SETUP_W-1:0]     sel_setup;
  logic                   sel_current;
  logic [NUM_SETUP-1:0]   offset_valid;

  // Named events for the assertions and the submodules
  logic idle_write, want_cal, refuse, cal_accept, cal_reject, plain_write;
  logic cal_finish, busy, offset_done;

  cal_chan_select #(.NUM_CH(NUM_CH), .SETUP_W(SETUP_W)) u_sel (
    .ch_en        (ch_en),
    .ch_setup     (ch_setup),
    .ch_is_current(ch_is_current),
    .one_ch       (one_ch),
    .sel_setup    (sel_setup),
    .sel_current  (sel_current)
  );

  assign busy        = (state_q != SQ_IDLE);
  assign idle_write  = mode_wr && !busy;
  assign want_cal    = is_cal_mode(mode_wdata);
  assign refuse      = !one_ch
                     || ((mode_wdata == MODE_INT_FS) && sel_current)
                     || (is_full_scale(mode_wdata) && !offset_valid[sel_setup]);
  assign cal_accept  = idle_write && want_cal && !refuse;
  assign cal_reject  = idle_write && want_cal && refuse;
  assign plain_write = idle_write && !want_cal;
  assign cal_finish  = (state_q == SQ_WAIT) && conv_done;
  assign offset_done = cal_finish && !is_full_scale(mode_cur);

  cal_offset_track #(.NUM_SETUP(NUM_SETUP), .SETUP_W(SETUP_W), .REF_W(REF_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_sel     (ref_sel),
    .set_en      (offset_done),
    .set_setup   (cal_setup_q),
    .offset_valid(offset_valid)
  );

  cal_ready_out u_rdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cal_start (cal_accept),
    .cal_finish(cal_finish),
    .busy      (busy),
    .rdy_pin   (rdy_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      mode_cur    <= MODE_STANDBY;
      cal_err     <= 1'b0;
      rdy_bit     <= 1'b0;
      cal_setup_q <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (cal_accept) begin
            state_q     <= SQ_START;
            mode_cur    <= mode_wdata;
            cal_err     <= 1'b0;
            rdy_bit     <= 1'b1;
            cal_setup_q <= sel_setup;
          end else if (cal_reject) begin
            cal_err <= 1'b1;
          end else if (plain_write) begin
            mode_cur <= mode_wdata;
            cal_err  <= 1'b0;
          end
        end
        SQ_START: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (conv_done) begin
            state_q  <= SQ_IDLE;
            mode_cur <= MODE_STANDBY;
            rdy_bit  <= 1'b0;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_wr_en    <= 1'b0;
      coef_wr_gain  <= 1'b0;
      coef_wr_setup <= '0;
      coef_wr_data  <= '0;
    end else begin
      coef_wr_en <= cal_finish;
      if (cal_finish) begin
        coef_wr_gain  <= is_full_scale(mode_cur);
        coef_wr_setup <= cal_setup_q;
        coef_wr_data  <= conv_result;
      end
    end
  end

  assign conv_start = (state_q == SQ_START);
  assign mux_sel    = busy ? mux_for(mode_cur) : MUX_PINS;

  AST_START_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> $onehot($past(ch_en))); // R1
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_reject |=> (cal_err && !rdy_bit && !conv_start && mode_cur == $past(mode_cur))); // R1
  AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cal_accept |=> (rdy_bit && conv_start && !cal_err)); // R2
  AST_MUX_PINS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_bit |-> (mux_sel == MUX_PINS)); // R3
  AST_WRITE_AT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_en |-> (!rdy_bit && mode_cur == MODE_STANDBY)); // R4
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_en |=> !coef_wr_en); // R4
  AST_NO_INT_FS_ON_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_start) && mode_cur == MODE_INT_FS) |-> !$past(|(ch_en & ch_is_current))); // R6
  AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || (busy && !conv_done)) |=> (mode_cur == $past(mode_cur) && rdy_bit)); // R9

endmodule

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
  localparam int NUM_CH    = 8;
  localparam int NUM_SETUP = 4;
  localparam int DATA_W    = 24;
  localparam int REF_W     = 2;
  localparam int SETUP_W   = 2;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       mode_wr = 1'b0;
  logic [2:0]                 mode_wdata = '0;
  logic [NUM_CH-1:0]          ch_en = '0;
  logic [NUM_CH*SETUP_W-1:0]  ch_setup;
  logic [NUM_CH-1:0]          ch_is_current = 8'hF0;
  logic [NUM_SETUP*REF_W-1:0] ref_sel = '0;
  logic                       cs_n = 1'b0;
  logic                       conv_done = 1'b0;
  logic [DATA_W-1:0]          conv_result = '0;
  logic                       conv_start;
  logic [1:0]                 mux_sel;
  logic                       coef_wr_en, coef_wr_gain;
  logic [SETUP_W-1:0]         coef_wr_setup;
  logic [DATA_W-1:0]          coef_wr_data;
  logic [2:0]                 mode_cur;
  logic                       rdy_bit, rdy_pin, cal_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  initial begin
    for (int i = 0; i < NUM_CH; i++) ch_setup[i*SETUP_W +: SETUP_W] = SETUP_W'(i % NUM_SETUP);
  end

  cal_sequencer dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ch_en(ch_en), .ch_setup(ch_setup), .ch_is_current(ch_is_current),
    .ref_sel(ref_sel), .cs_n(cs_n), .conv_done(conv_done), .conv_result(conv_result),
    .conv_start(conv_start), .mux_sel(mux_sel), .coef_wr_en(coef_wr_en),
    .coef_wr_gain(coef_wr_gain), .coef_wr_setup(coef_wr_setup),
    .coef_wr_data(coef_wr_data), .mode_cur(mode_cur), .rdy_bit(rdy_bit),
    .rdy_pin(rdy_pin), .cal_err(cal_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_phase = 0;      // 0 idle, 1 start cycle, 2 waiting for done
  int m_mode = 0, m_err = 0, m_rdy = 0, m_pin = 0, m_setup = 0;
  int m_wr = 0, m_gain = 0, m_wsetup = 0;
  longint m_wdata = 0;
  bit m_valid[NUM_SETUP];
  int m_ref_prev[NUM_SETUP];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mode = 0; m_err = 0; m_rdy = 0; m_pin = 0; m_wr = 0;
      for (int s = 0; s < NUM_SETUP; s++) begin m_valid[s] = 0; m_ref_prev[s] = 0; end
    end else begin
      int n_en, ch, st, code;
      bit is_cal, fs, bad, fin, acc;
      bit nv[NUM_SETUP];
      n_en = 0; ch = 0;
      for (int i = 0; i < NUM_CH; i++) if (ch_en[i]) begin n_en++; ch = i; end
      st = ch % NUM_SETUP;
      code = int'(mode_wdata);
      is_cal = (code >= 1 && code <= 4);
      fs = (code == 2 || code == 4);
      bad = (n_en != 1) || (code == 2 && ch >= 4) || (fs && !m_valid[st]);
      fin = (m_phase == 2) && conv_done;
      acc = (m_phase == 0) && mode_wr && is_cal && !bad;
      for (int s = 0; s < NUM_SETUP; s++) begin
        int r;
        r = int'(ref_sel[s*REF_W +: REF_W]);
        nv[s] = m_valid[s];
        if (r != m_ref_prev[s]) nv[s] = 0;
        else if (fin && (m_mode == 1 || m_mode == 3) && s == m_setup) nv[s] = 1;
        m_ref_prev[s] = r;
      end
      m_wr = fin;
      if (fin) begin
        m_gain = (m_mode == 2 || m_mode == 4); m_wsetup = m_setup; m_wdata = longint'(conv_result);
      end
      if (acc) m_pin = 1;
      else if (!cs_n && (m_phase == 0 || fin)) m_pin = 0;
      if (m_phase == 0 && mode_wr) begin
        if (acc) begin m_phase = 1; m_mode = code; m_err = 0; m_rdy = 1; m_setup = st; end
        else if (is_cal) m_err = 1;
        else begin m_mode = code; m_err = 0; end
      end else if (m_phase == 1) m_phase = 2;
      else if (fin) begin m_phase = 0; m_mode = 0; m_rdy = 0; end
      for (int s = 0; s < NUM_SETUP; s++) m_valid[s] = nv[s];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int emux;
      emux = (m_phase == 0) ? 0 : (m_mode == 1) ? 1 : (m_mode == 2) ? 2 : 0;
      chk("R2 conv_start", conv_start, m_phase == 1);
      chk("R2 rdy_bit", rdy_bit, m_rdy);
      chk("R5 rdy_pin", rdy_pin, m_pin);
      chk("R9 mode_cur", mode_cur, m_mode);
      chk("R1 cal_err", cal_err, m_err);
      chk("R3 mux_sel", mux_sel, emux);
      chk("R4 coef_wr_en", coef_wr_en, m_wr);
      if (m_wr) begin
        chk("R4 coef_wr_gain", coef_wr_gain, m_gain);
        chk("R4 coef_wr_setup", coef_wr_setup, m_wsetup);
        chk("R4 coef_wr_data", coef_wr_data, m_wdata);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_mode(input logic [2:0] code, input logic [NUM_CH-1:0] en);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = code; ch_en = en;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic finish_cal(input logic [DATA_W-1:0] val, input int exp_gain, input int exp_setup);
    idle(3);
    conv_done = 1'b1; conv_result = val;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R4 write strobe", coef_wr_en, 1);
    chk("R4 gain select", coef_wr_gain, exp_gain);
    chk("R4 setup", coef_wr_setup, exp_setup);
    chk("R4 data", coef_wr_data, val);
    chk("R4 standby", mode_cur, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset rdy_bit", rdy_bit, 0);
    chk("reset rdy_pin", rdy_pin, 0);
    chk("reset mode", mode_cur, 0);

    // Gain step before any offset: refused
    write_mode(3'd4, 8'h02);
    chk("R7 gain without offset refused", cal_err, 1);
    chk("R7 no ready", rdy_bit, 0);
    // Zero and two channels enabled
    write_mode(3'd1, 8'h00);
    chk("R1 zero channels refused", cal_err, 1);
    write_mode(3'd1, 8'h06);
    chk("R1 two channels refused", cal_err, 1);
    chk("R1 mode kept", mode_cur, 0);

    // Internal offset on channel 1 (setup 1), chip select low
    cs_n = 1'b0;
    write_mode(3'd1, 8'h02);
    chk("R2 ready up", rdy_bit, 1);
    chk("R2 pin up", rdy_pin, 1);
    chk("R2 mode", mode_cur, 1);
    chk("R3 short to negative", mux_sel, 1);
    write_mode(3'd0, 8'h02);
    chk("R9 write while busy ignored", mode_cur, 1);
    finish_cal(24'h80_1234, 0, 1);
    chk("R5 pin low with cs low", rdy_pin, 0);

    // Internal gain on channel 1 with chip select high
    cs_n = 1'b1;
    write_mode(3'd2, 8'h02);
    chk("R3 full-scale source", mux_sel, 2);
    finish_cal(24'h55_AA55, 1, 1);
    chk("R5 pin held with cs high", rdy_pin, 1);
    idle(2);
    chk("R5 pin still held", rdy_pin, 1);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R5 pin drops on cs low", rdy_pin, 0);

    // Internal gain on a current channel (5, setup 1 has offset) refused
    write_mode(3'd2, 8'h20);
    chk("R6 current channel refused", cal_err, 1);
    chk("R6 no start", rdy_bit, 0);

    // System offset then system gain on channel 2
    write_mode(3'd3, 8'h04);
    chk("R2 error cleared", cal_err, 0);
    chk("R3 system routing", mux_sel, 0);
    finish_cal(24'h7F_FFF0, 0, 2);
    write_mode(3'd4, 8'h04);
    chk("R7 gain accepted after offset", rdy_bit, 1);
    finish_cal(24'h5F_0001, 1, 2);

    // Reference change invalidates setup 2
    ref_sel[2*REF_W +: REF_W] = 2'd1;
    idle(2);
    write_mode(3'd4, 8'h04);
    chk("R8 gain refused after ref change", cal_err, 1);
    write_mode(3'd4, 8'h02);
    chk("R8 other setup unaffected", rdy_bit, 1);
    finish_cal(24'h50_0000, 1, 1);

    // Plain modes and stray done pulses
    write_mode(3'd5, 8'h00);
    chk("R10 plain code stored", mode_cur, 5);
    chk("R10 no ready", rdy_bit, 0);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R4 stray done ignored", coef_wr_en, 0);
    write_mode(3'd0, 8'h00);
    chk("R10 standby stored", mode_cur, 0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule